// File: doc/BRIEF.md
# Four-Stage Stallable Register-Machine Pipeline

This block is a small processor core whose program and data share one local register RAM. Every instruction names a destination word D and a source word S in that RAM. The immediate flag can turn S into a literal. The core moves each instruction through four phases in turn: fetch from the RAM, decode, operand read with execute, and write-back of D. It starts the next instruction only after the previous one has written back. Every instruction therefore takes exactly four clock cycles, and a word stored by one instruction is what the next fetch from that address returns.

Two instruction kinds can hold the core in its third phase, and only there. A shared-memory read raises a request and waits for a grant. A wait-until-equal instruction waits until an external input equals its S operand. Branches take four cycles whether or not they are taken. These are decrement-and-jump-if-nonzero, jump-if-zero, jump-if-nonzero and an unconditional jump. While reset is held, a load port fills the RAM with a program and its data. A retire strobe and a write-back bus show each instruction as it completes.

Top module: `reg_pipe_core`

## Requirements
- R1: While reset is low, `retire`, `wb_valid`, `mem_req` and `stall` are 0. After reset is released, the first instruction comes from address 0 and retires in the third cycle after release.
- R2: Each instruction passes through fetch, decode, read/execute and write-back, one cycle each. Without a stall, `retire` pulses every 4 cycles.
- R3: An instruction word holds the opcode in bits 31:28, the write enable in bit 27, the immediate flag in bit 26, D in bits 17:9 and S in bits 8:0. With the immediate flag set, the S operand is S zero-extended; otherwise it is RAM[S].
- R4: Opcodes 0 to 5 write the following value to D: S (0), D+S (1), D-S (2), D&S (3), D|S (4), D^S (5). Values wrap modulo 2^32.
- R5: When the write enable is 0, no RAM word changes and `wb_valid` stays 0 during that retire.
- R6: Opcode 6 computes D-1 as its result. It jumps to the low 9 bits of the S operand if that result is nonzero, and otherwise goes to the next address.
- R7: Opcode 7 jumps when D is zero, opcode 8 jumps when D is nonzero, and opcode 11 always jumps. Taken and not-taken branches both keep the 4-cycle spacing.
- R8: An instruction fetched from the address the previous instruction just wrote executes the newly written word.
- R9: Opcode 9 raises `mem_req` with `mem_addr` equal to the low 16 bits of the S operand. `mem_req` and `mem_addr` are held until a cycle in which `mem_grant` is 1. In that cycle `mem_rdata` is taken as the result, and the instruction retires one cycle later.
- R10: Opcode 10 stalls while `wait_in` differs from the S operand. The result is `wait_in`, and the instruction retires one cycle after the cycle in which the two are equal.
- R11: While reset is low, `ld_en` writes `ld_data` into RAM[`ld_addr`] at the clock edge.
- R12: `stall` is high only in the read/execute phase. No instruction retires while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_en | input | 1 | Program load write strobe |
| ld_addr | input | 9 | Program load address |
| ld_data | input | 32 | Program load data |
| mem_grant | input | 1 | Shared-memory grant |
| mem_rdata | input | 32 | Shared-memory read data |
| wait_in | input | 32 | Value compared by the wait instruction |
| mem_req | output | 1 | Shared-memory request |
| mem_addr | output | 16 | Shared-memory address |
| stall | output | 1 | Read/execute phase held |
| retire | output | 1 | Write-back phase of an instruction |
| retire_pc | output | 9 | Address of the retiring instruction |
| wb_valid | output | 1 | D written this cycle |
| wb_addr | output | 9 | D address being written |
| wb_data | output | 32 | Value being written |

## Verification
The bench runs a decrement loop that branches back to itself, followed by zero and nonzero tests that both take and skip. A core that shortened a not-taken branch, or that tested the value before decrementing, would show the wrong retire addresses or break the 4-cycle spacing. A self-modifying pair overwrites the very next instruction, so a core that fetched too early would execute the stale word and write 3 instead of 7. The shared-memory read and the wait instruction are each held for several cycles. This exposes a core that retires during the stall, drops its request before the grant, or adds an extra cycle after release. The bench also runs an instruction with its write enable cleared and then copies D, which exposes a core that wrote D anyway.

// File: rtl/reg_pipe_core.sv
module reg_pipe_core #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  parameter int MAW   = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int IRW  = 6 + 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          mem_grant,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] wait_in,
  output logic          mem_req,
  output logic [MAW-1:0] mem_addr,
  output logic          stall,
  output logic          retire,
  output logic [AW-1:0] retire_pc,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data
);

  typedef enum logic [1:0] {PH_F, PH_D, PH_R, PH_W} phase_t;

  localparam logic [3:0] OP_MOV  = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_DJNZ = 4'd6;
  localparam logic [3:0] OP_TJZ  = 4'd7;
  localparam logic [3:0] OP_TJNZ = 4'd8;
  localparam logic [3:0] OP_RDSH = 4'd9;
  localparam logic [3:0] OP_WTEQ = 4'd10;
  localparam logic [3:0] OP_JMP  = 4'd11;

  logic [DW-1:0]  ram [DEPTH];
  phase_t         ph;
  logic [AW-1:0]  pc, pc_inc_q, npc_q;
  logic [IRW-1:0] ir;
  logic [3:0]     op_q;
  logic           wr_q, imm_q;
  logic [AW-1:0]  s_q, d_q;
  logic [DW-1:0]  s_lit_q, res_q;

  logic [DW-1:0]  s_val, d_val, alu;
  logic           taken, hold;

  always_ff @(posedge clk) begin
    if (ld_en) ram[ld_addr] <= ld_data;
    else if (ph == PH_W && wr_q) ram[d_q] <= res_q;
  end

  assign s_val = imm_q ? s_lit_q : ram[s_q];
  assign d_val = ram[d_q];

  always_comb begin
    alu   = d_val;
    taken = 1'b0;
    hold  = 1'b0;
    case (op_q)
      OP_MOV:  alu = s_val;
      OP_ADD:  alu = d_val + s_val;
      OP_SUB:  alu = d_val - s_val;
      OP_AND:  alu = d_val & s_val;
      OP_OR:   alu = d_val | s_val;
      OP_XOR:  alu = d_val ^ s_val;
      OP_DJNZ: begin
        alu   = d_val - 1'b1;
        taken = (d_val != {{(DW-1){1'b0}}, 1'b1});
      end
      OP_TJZ:  taken = (d_val == '0);
      OP_TJNZ: taken = (d_val != '0);
      OP_JMP:  taken = 1'b1;
      OP_RDSH: begin
        alu  = mem_rdata;
        hold = !mem_grant;
      end
      OP_WTEQ: begin
        alu  = wait_in;
        hold = (wait_in != s_val);
      end
      default: alu = d_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_F;
      pc       <= '0;
      ir       <= '0;
      op_q     <= '0;
      wr_q     <= 1'b0;
      imm_q    <= 1'b0;
      s_q      <= '0;
      d_q      <= '0;
      s_lit_q  <= '0;
      pc_inc_q <= '0;
      npc_q    <= '0;
      res_q    <= '0;
    end else begin
      case (ph)
        PH_F: begin
          ir <= {ram[pc][DW-1:DW-6], ram[pc][2*AW-1:0]};
          ph <= PH_D;
        end
        PH_D: begin
          op_q     <= ir[IRW-1:IRW-4];
          wr_q     <= ir[IRW-5];
          imm_q    <= ir[IRW-6];
          d_q      <= ir[2*AW-1:AW];
          s_q      <= ir[AW-1:0];
          s_lit_q  <= {{(DW-AW){1'b0}}, ir[AW-1:0]};
          pc_inc_q <= pc + 1'b1;
          ph       <= PH_R;
        end
        PH_R: begin
          if (!hold) begin
            res_q <= alu;
            npc_q <= taken ? s_val[AW-1:0] : pc_inc_q;
            ph    <= PH_W;
          end
        end
        default: begin
          pc <= npc_q;
          ph <= PH_F;
        end
      endcase
    end
  end

  assign mem_req   = (ph == PH_R) && (op_q == OP_RDSH);
  assign mem_addr  = s_val[MAW-1:0];
  assign stall     = (ph == PH_R) && hold;
  assign retire    = (ph == PH_W);
  assign retire_pc = pc;
  assign wb_valid  = retire && wr_q;
  assign wb_addr   = d_q;
  assign wb_data   = res_q;

endmodule

// File: rtl/reg_pipe_core_chk.sv
module reg_pipe_core_chk #(
  parameter int MAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_grant,
  input logic [MAW-1:0] mem_addr,
  input logic           stall,
  input logic           retire,
  input logic           wb_valid
);

  logic [2:0] gap;
  logic       seen, st_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '0;
      seen    <= 1'b0;
      st_seen <= 1'b0;
    end else begin
      if (retire) begin
        gap     <= 3'd1;
        seen    <= 1'b1;
        st_seen <= 1'b0;
      end else begin
        if (gap != 3'd7) gap <= gap + 3'd1;
        if (stall) st_seen <= 1'b1;
      end
    end
  end

  a_r2_four_cycle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && seen && !st_seen) |-> (gap == 3'd4));

  a_r12_no_retire_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !retire);

  a_r5_write_only_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> retire);

  a_r9_ungranted_req_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_grant) |-> stall);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_grant) |=> (mem_req && $stable(mem_addr)));

  a_r9_grant_ends_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_grant) |=> (retire && !mem_req));

endmodule

bind reg_pipe_core reg_pipe_core_chk #(.MAW(MAW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_grant (mem_grant),
  .mem_addr  (mem_addr),
  .stall     (stall),
  .retire    (retire),
  .wb_valid  (wb_valid)
);

// File: tb/test_reg_pipe_core.sv
module test_reg_pipe_core;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic          mem_grant = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic [31:0]   wait_in = '0;
  logic          mem_req, stall, retire, wb_valid;
  logic [15:0]   mem_addr;
  logic [AW-1:0] retire_pc, wb_addr;
  logic [31:0]   wb_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  reg_pipe_core i_reg_pipe_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .mem_grant(mem_grant), .mem_rdata(mem_rdata), .wait_in(wait_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .stall(stall), .retire(retire),
    .retire_pc(retire_pc), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  always #10 clk = ~clk;

  always_ff @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  function automatic logic [31:0] enc(int op, bit wr, bit imm, int d, int s);
    return {op[3:0], wr, imm, 8'h00, d[8:0], s[8:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic put(int a, logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1;
    ld_addr = a[AW-1:0];
    ld_data = d;
  endtask

  task automatic go();
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic at(int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic t_reset();
    hold_reset();
    repeat (3) @(negedge clk);
    chk("R1 retire in reset", 32'(retire), 0);
    chk("R1 wb_valid in reset", 32'(wb_valid), 0);
    chk("R1 mem_req in reset", 32'(mem_req), 0);
    chk("R12 stall in reset", 32'(stall), 0);
  endtask

  task automatic t_alu();
    logic [31:0] exp_d [8];
    hold_reset();
    put(101, 32'd10);
    put(0, enc(0, 1, 1, 100, 5));
    put(1, enc(1, 1, 1, 100, 3));
    put(2, enc(2, 1, 0, 100, 101));
    put(3, enc(5, 1, 1, 100, 9'h1FF));
    put(4, enc(3, 1, 1, 100, 8'hFF));
    put(5, enc(4, 1, 1, 100, 8'h10));
    put(6, enc(0, 0, 1, 100, 1));
    put(7, enc(0, 1, 0, 102, 100));
    put(8, enc(11, 0, 1, 0, 8));
    go();
    exp_d = '{32'd5, 32'd8, 32'hFFFF_FFFE, 32'hFFFF_FE01, 32'h1, 32'h11, 32'h0, 32'h11};
    at(2);
    chk("R2 no retire before third cycle", 32'(retire), 0);
    for (int k = 0; k < 9; k++) begin
      at(3 + 4 * k);
      chk("R2 retire every 4 cycles", 32'(retire), 1);
      chk("R1 R2 retire address", 32'(retire_pc), k);
      if (k < 8 && k != 6) begin
        chk("R4 R11 alu result", wb_data, exp_d[k]);
        chk("R3 write address", 32'(wb_addr), (k == 7) ? 102 : 100);
      end
      if (k == 6) chk("R5 write enable clear", 32'(wb_valid), 0);
      if (k == 7) chk("R5 D unchanged after disabled write", wb_data, 32'h11);
      @(negedge clk);
      chk("R2 single-cycle retire", 32'(retire), 0);
      chk("R9 no request for alu ops", 32'(mem_req), 0);
    end
  endtask

  task automatic t_branch();
    int exp_pc [8] = '{0, 0, 0, 1, 4, 5, 6, 8};
    hold_reset();
    put(30, 32'd3);
    put(31, 32'd7);
    put(0, enc(6, 1, 1, 30, 0));
    put(1, enc(7, 0, 1, 30, 4));
    put(4, enc(8, 0, 1, 30, 9));
    put(5, enc(7, 0, 1, 31, 2));
    put(6, enc(8, 0, 1, 31, 8));
    put(8, enc(11, 0, 1, 0, 8));
    go();
    for (int k = 0; k < 8; k++) begin
      at(3 + 4 * k);
      chk("R6 R7 branch retire timing", 32'(retire), 1);
      chk("R6 R7 branch path", 32'(retire_pc), exp_pc[k]);
      if (k < 3) chk("R6 decrement result", wb_data, 32'(2 - k));
      if (k == 3) chk("R7 test does not write", 32'(wb_valid), 0);
    end
  endtask

  task automatic t_selfmod();
    logic [31:0] nw;
    nw = enc(0, 1, 1, 20, 7);
    hold_reset();
    put(40, nw);
    put(0, enc(0, 1, 0, 1, 40));
    put(1, enc(0, 1, 1, 20, 3));
    put(2, enc(11, 0, 1, 0, 2));
    go();
    at(3);
    chk("R8 rewrite word", wb_data, nw);
    chk("R8 rewrite address", 32'(wb_addr), 1);
    at(7);
    chk("R8 next fetch sees new word", wb_data, 32'd7);
    chk("R8 new word destination", 32'(wb_addr), 20);
  endtask

  task automatic t_shared();
    hold_reset();
    put(0, enc(9, 1, 1, 50, 9'h123));
    put(1, enc(11, 0, 1, 0, 1));
    go();
    for (int c = 2; c <= 6; c++) begin
      at(c);
      chk("R9 request held", 32'(mem_req), 1);
      chk("R12 stall while ungranted", 32'(stall), 1);
      chk("R12 no retire during stall", 32'(retire), 0);
    end
    chk("R9 request address", 32'(mem_addr), 32'h123);
    at(7);
    mem_grant = 1'b1;
    mem_rdata = 32'hCAFE_0001;
    at(8);
    mem_grant = 1'b0;
    mem_rdata = '0;
    chk("R9 retire after grant", 32'(retire), 1);
    chk("R9 shared data written", wb_data, 32'hCAFE_0001);
    chk("R9 request dropped", 32'(mem_req), 0);
    at(12);
    chk("R2 spacing resumes after stall", 32'(retire), 1);
    chk("R2 next address after stall", 32'(retire_pc), 1);
  endtask

  task automatic t_wait();
    hold_reset();
    wait_in = 32'h54;
    put(0, enc(10, 1, 1, 60, 8'h55));
    put(1, enc(11, 0, 1, 0, 1));
    go();
    at(4);
    chk("R10 stall while unequal", 32'(stall), 1);
    chk("R10 no shared request", 32'(mem_req), 0);
    at(6);
    chk("R10 no retire while unequal", 32'(retire), 0);
    wait_in = 32'h55;
    at(7);
    chk("R10 retire after match", 32'(retire), 1);
    chk("R10 result is wait value", wb_data, 32'h55);
    chk("R12 stall cleared", 32'(stall), 0);
    wait_in = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_alu();
    t_branch();
    t_selfmod();
    t_shared();
    t_wait();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule